// File: doc/BRIEF.md
# Zero-Run Gated Bit-Clock Recovery

This block recovers the bit clock of a slow FSK receive channel from a stream of oversampled demodulator decisions. A small phase counter advances once per sample strobe. Each time the counter wraps, the block takes a bit. While correction is allowed, every level change in the received samples pulls the sampling point one sample toward the middle of the bit.

Long stretches of constant data give the loop nothing to lock to, and it can then slip, which adds or drops bits. To prevent this, a control part counts consecutive decoded 0 bits. Once the run reaches a programmed length, counted in whole bytes, the control part freezes the phase correction. The next decoded 1 releases it again. A programmed length of zero holds the loop frozen at all times. That setting is the usual one after reset.

Top module: `dpll_zero_freeze`

## Requirements
- R1: While reset is held, `bitValid` is low and the zero-run count is cleared. `dpllFrozen` is therefore high when `runBytes` is 0 and low otherwise.
- R2: The phase counter runs from 0 to SPB-1 (SPB = 8) and advances on each `sampleEn` strobe. It holds when there is no strobe. The bit is taken on the strobe where the advanced phase wraps to 0. One clock later `bitValid` pulses for one cycle, and `bitData` equals the `rxLevel` of that strobe. After reset, a level change seen when the advanced phase is SPB/2 puts the take exactly 4 strobes after the change and 4 strobes before the next bit boundary, and it causes no correction.
- R3: If a level change is seen on a strobe whose advanced phase is above SPB/2 while not frozen, the stored phase is lowered by one. The next take then comes one strobe later.
- R4: If a level change is seen on a strobe whose advanced phase is below SPB/2 while not frozen, the stored phase is raised by one. The next take then comes one strobe earlier.
- R5: While `dpllFrozen` is high, level changes make no correction: the phase advances by exactly one per strobe.
- R6: With `runBytes` = 0, `dpllFrozen` is high whatever data arrives.
- R7: With `runBytes` = N ≥ 1, `dpllFrozen` goes high in the same cycle as the `bitValid` of the N×8-th consecutive decoded 0. It is still low for the run of N×8−1 zeros.
- R8: With `runBytes` ≥ 1, a decoded 1 clears the zero-run count. `dpllFrozen` falls in the same cycle as that bit's `bitValid`.
- R9: The zero-run count saturates at its maximum (2047 for the defaults) and does not wrap. With `runBytes` = 255, the loop stays frozen through runs longer than 2048 zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | One pulse per demodulator sample (SPB per bit) |
| rxLevel | input | 1 | Hard-decided demodulator level for this sample |
| runBytes | input | RUN_W | Zero-run length in bytes that triggers the freeze; 0 means always frozen |
| bitValid | output | 1 | One-cycle pulse per recovered bit |
| bitData | output | 1 | Recovered bit value, valid with `bitValid` |
| dpllFrozen | output | 1 | High while phase correction is disabled |

## Verification
The recovered-bit path is driven with several mixed patterns: alternating data, all ones, long zero runs split by single ones, and runs that stop one bit short of the limit. These patterns separate a correct `>=` threshold from an off-by-one, and a clearing 1 from a missed clear. Edges placed one sample late or one sample early are sent both frozen and unfrozen. The position of the next take within the bit shows whether a correction happened and in which direction. A run of 2100 zeros at the largest setting separates a saturating count from a wrapping one. Idle gaps between strobes confirm that the phase only advances on a sample.

// File: rtl/dzf_pkg.sv
package dzf_pkg;
  // strobe from the bit-clock datapath to the run control
  typedef struct packed {
    logic take;   // a bit is taken on this strobe
    logic value;  // level of the taken bit
  } bitEvt_t;

  // control word from the run control to the datapath
  typedef struct packed {
    logic freeze; // suppress phase correction
  } dpllCtl_t;
endpackage

// File: rtl/dzf_dpll.sv
module dzf_dpll
  import dzf_pkg::*;
#(
  parameter int SPB  = 8,
  parameter int PH_W = $clog2(SPB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleEn,
  input  logic            rxLevel,
  input  dpllCtl_t        ctl,
  output bitEvt_t         evt,
  output logic            bitValid,
  output logic            bitData,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SPB - 1);
  localparam logic [PH_W-1:0] MID  = PH_W'(SPB / 2);

  logic [PH_W-1:0] ph, incPh, nextPh;
  logic            prevLevel, edgeSeen;

  always_comb begin
    incPh    = (ph == LAST) ? '0 : ph + 1'b1;
    edgeSeen = rxLevel ^ prevLevel;
    nextPh   = incPh;
    if (edgeSeen && !ctl.freeze) begin
      if (incPh > MID)      nextPh = incPh - 1'b1;
      else if (incPh < MID) nextPh = incPh + 1'b1;
    end
    evt.take  = sampleEn && (incPh == '0);
    evt.value = rxLevel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      prevLevel <= 1'b0;
      bitValid  <= 1'b0;
      bitData   <= 1'b0;
    end else begin
      bitValid <= evt.take;
      if (evt.take) bitData <= rxLevel;
      if (sampleEn) begin
        ph        <= nextPh;
        prevLevel <= rxLevel;
      end
    end
  end

  assign phase = ph;
endmodule

// File: rtl/dzf_runctl.sv
module dzf_runctl
  import dzf_pkg::*;
#(
  parameter int RUN_W = 8,
  parameter int CNT_W = RUN_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RUN_W-1:0] runBytes,
  input  bitEvt_t          evt,
  output dpllCtl_t         ctl,
  output logic [CNT_W-1:0] zeroRun
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] zeroCnt, thresh;

  always_ff @(posedge clk) begin
    if (!rst_n)
      zeroCnt <= '0;
    else if (evt.take) begin
      if (evt.value)               zeroCnt <= '0;
      else if (zeroCnt != CNT_MAX) zeroCnt <= zeroCnt + 1'b1;
    end
  end

  always_comb begin
    thresh     = {runBytes, 3'b000};
    ctl.freeze = (runBytes == '0) || (zeroCnt >= thresh);
  end

  assign zeroRun = zeroCnt;
endmodule

// File: rtl/dpll_zero_freeze.sv
module dpll_zero_freeze
  import dzf_pkg::*;
#(
  parameter int SPB   = 8,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleEn,
  input  logic             rxLevel,
  input  logic [RUN_W-1:0] runBytes,
  output logic             bitValid,
  output logic             bitData,
  output logic             dpllFrozen
);
  localparam int PH_W  = $clog2(SPB);
  localparam int CNT_W = RUN_W + 3;

  bitEvt_t          evt;
  dpllCtl_t         ctl;
  logic [PH_W-1:0]  dpllPhase;
  logic [CNT_W-1:0] zeroRun;

  dzf_dpll #(.SPB(SPB), .PH_W(PH_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .rxLevel(rxLevel),
    .ctl(ctl), .evt(evt), .bitValid(bitValid), .bitData(bitData),
    .phase(dpllPhase)
  );

  dzf_runctl #(.RUN_W(RUN_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .runBytes(runBytes), .evt(evt),
    .ctl(ctl), .zeroRun(zeroRun)
  );

  assign dpllFrozen = ctl.freeze;
endmodule

// File: rtl/dzf_checker.sv
module dzf_checker #(
  parameter int SPB   = 8,
  parameter int RUN_W = 8,
  parameter int PH_W  = $clog2(SPB),
  parameter int CNT_W = RUN_W + 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleEn,
  input logic [RUN_W-1:0] runBytes,
  input logic             bitValid,
  input logic             bitData,
  input logic             dpllFrozen,
  input logic [PH_W-1:0]  phase,
  input logic [CNT_W-1:0] zeroRun
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |=> !bitValid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleEn |=> ($stable(phase) && !bitValid));

  assert_frozen_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleEn && dpllFrozen) |=> (phase == PH_W'($past(phase) + 1'b1)));

  assert_zero_setting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (runBytes == '0) |-> dpllFrozen);

  assert_one_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (runBytes != '0 && bitValid && bitData) |-> !dpllFrozen);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (zeroRun == CNT_MAX) |=> ((zeroRun == CNT_MAX) || (bitValid && bitData)));
endmodule

bind dpll_zero_freeze dzf_checker #(.SPB(SPB), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .runBytes(runBytes),
  .bitValid(bitValid), .bitData(bitData), .dpllFrozen(dpllFrozen),
  .phase(dpllPhase), .zeroRun(zeroRun)
);

// File: tb/dpll_zero_freeze_tb.sv
module dpll_zero_freeze_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, sampleEn, rxLevel;
  logic [7:0] runBytes;
  logic       bitValid, bitData, dpllFrozen;

  int nChecks = 0;
  int nFails  = 0;
  int zrun    = 0;
  bit done    = 1'b0;

  // {runBytes, 24 bits sent LSB first}
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 24'hA5C3F0},
    {8'd1, 24'h000F01},
    {8'd2, 24'h800000},
    {8'd1, 24'h555555},
    {8'd3, 24'hFFFFFF},
    {8'd1, 24'h800100}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_zero_freeze u_dut (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .rxLevel(rxLevel),
    .runBytes(runBytes), .bitValid(bitValid), .bitData(bitData),
    .dpllFrozen(dpllFrozen)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expFrz();
    return (runBytes == 8'd0 || zrun >= int'(runBytes) * 8) ? 1 : 0;
  endfunction

  task automatic strobe(input logic lvl);
    rxLevel  = lvl;
    sampleEn = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendBitN(input logic b, input int n, input int takeIdx, input string req);
    for (int i = 0; i < n; i++) begin
      strobe(b);
      if (i == takeIdx) zrun = b ? 0 : zrun + 1;
      chk({req, " R2 take position"}, int'(bitValid), (i == takeIdx) ? 1 : 0);
      if (i == takeIdx) chk({req, " R2 bit value"}, int'(bitData), int'(b));
      chk({req, " R6 R7 R8 freeze"}, int'(dpllFrozen), expFrz());
    end
  endtask

  task automatic extraStrobe(input logic lvl);
    strobe(lvl);
    chk("extra strobe R2 no take", int'(bitValid), 0);
    chk("extra strobe R7 freeze", int'(dpllFrozen), expFrz());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sampleEn = 1'b0;
      @(negedge clk);
      chk("idle R2 no take", int'(bitValid), 0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sampleEn = 1'b0; rxLevel = 1'b0; runBytes = 8'd5;
    @(negedge clk); @(negedge clk);
    chk("R1 reset bitValid", int'(bitValid), 0);
    chk("R1 reset freeze with nonzero length", int'(dpllFrozen), 0);
    runBytes = 8'd0;
    @(negedge clk);
    chk("R1 reset freeze with zero length", int'(dpllFrozen), 1);
    rst_n = 1'b1;

    // preamble: three strobes so the first boundary lands at phase 4
    for (int i = 0; i < 3; i++) extraStrobe(1'b0);

    // table walk: aligned edges, several data patterns and run lengths
    for (int v = 0; v < 6; v++) begin
      runBytes = VEC[v][31:24];
      for (int k = 0; k < 24; k++) sendBitN(VEC[v][k], 8, 4, "table");
      idle(2);
    end

    // late edge while frozen: no correction (R5)
    runBytes = 8'd0;
    extraStrobe(1'b1);
    sendBitN(1'b0, 8, 3, "late frozen R5");
    sendBitN(1'b1, 8, 3, "late frozen R5");
    // late edge unfrozen: retarded by one (R3)
    runBytes = 8'd255;
    sendBitN(1'b0, 8, 4, "late unfrozen R3");
    // early edge unfrozen: advanced by one (R4)
    sendBitN(1'b1, 7, 4, "short bit");
    sendBitN(1'b0, 8, 4, "early unfrozen R4");
    // early edge frozen (R5), then realign (R4)
    runBytes = 8'd0;
    sendBitN(1'b1, 7, 4, "short bit");
    sendBitN(1'b0, 8, 5, "early frozen R5");
    runBytes = 8'd1;
    sendBitN(1'b1, 8, 4, "realign R4");

    // zero run freezes correction, a 1 releases it (R7 R5 R8 R3)
    for (int k = 0; k < 8; k++) sendBitN(1'b0, 8, 4, "run of eight R7");
    extraStrobe(1'b0);
    sendBitN(1'b1, 8, 3, "frozen by run R5");
    sendBitN(1'b0, 8, 4, "released by one R8 R3");

    // saturation at the largest setting (R9)
    runBytes = 8'd255;
    for (int k = 0; k < 2100; k++) sendBitN(1'b0, 8, 4, "long run R9");
    sendBitN(1'b1, 8, 4, "end of long run R8");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule